// File: doc/BRIEF.md
# MSI Memory-Mapped Write Decoder

This block is the bus-facing slave of a message-signaled interrupt receiver that serves several interrupt-file pages. Each page occupies one 4 KiB window of the address map. A device signals an interrupt by storing its identity number into the little-endian set-identity word at offset 0 of the target page. The decoder validates each access and finds the page from the upper address bits. For each accepted store it tells the interrupt-file storage which identity to mark pending on which page.

Misaligned accesses, partial-word accesses and accesses past the end of the map get an error response and have no other effect. For a well-formed store the block always asks for the page's interrupt outputs to be re-evaluated. A pending-set request is issued only when the store hits offset 0 and carries an identity that is nonzero and below the identity count. Stores to any other offset are ignored, including the big-endian word at offset 4. Reads always return zero. Each accepted access is answered one cycle later, and no new access is accepted in that response cycle.

Top module: `msi_write_decoder`

## Requirements
- R1: During and after reset, with no traffic, `rsp_valid`, `set_valid` and `eval_valid` are low and `req_ready` is high.
- R2: An access accepted on a clock edge (`req_valid` and `req_ready` high) produces exactly one `rsp_valid` cycle right after that edge. `req_ready` is low during that response cycle, so a held request is accepted on the following edge.
- R3: An access with `req_addr[1:0]` not zero, or with `req_be` not equal to 4'b1111, responds with `rsp_err`=1 and raises neither `set_valid` nor `eval_valid`.
- R4: An access with `req_addr` >= NUM_PAGES*4096 responds with `rsp_err`=1 and raises neither `set_valid` nor `eval_valid`.
- R5: The page reported on `set_page` and `eval_page` equals `req_addr >> 12`.
- R6: A well-formed write to page offset 0x000 whose data D satisfies 0 < D < NUM_IDS raises `set_valid` for one cycle with `set_id`=D, together with the response.
- R7: A well-formed write to offset 0x000 with data 0 or data >= NUM_IDS raises no `set_valid`. It still responds with `rsp_err`=0 and raises `eval_valid`.
- R8: A well-formed write to any offset other than 0x000, including the big-endian word at 0x004, raises no `set_valid`. It responds with `rsp_err`=0 and raises `eval_valid`.
- R9: Every read responds with `rsp_rdata`=0 and raises neither `set_valid` nor `eval_valid`. Its `rsp_err` follows R3 and R4.
- R10: `set_valid` and `eval_valid` are single-cycle pulses that occur only in a response cycle. `set_valid` is always accompanied by `eval_valid` for the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Decoder can accept an access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the decoder window |
| req_be | input | 4 | Byte enables; all four must be set |
| req_wdata | input | 32 | Write data (identity number) |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_err | output | 1 | Access was misaligned, partial or out of range |
| rsp_rdata | output | 32 | Read data, always zero |
| set_valid | output | 1 | Pending-set request strobe |
| set_page | output | PAGE_W | Page of the pending-set request |
| set_id | output | ID_W | Identity to mark pending |
| eval_valid | output | 1 | Re-evaluate interrupt outputs strobe |
| eval_page | output | PAGE_W | Page to re-evaluate |

## Verification
On every cycle the assertions check the handshake shape: one response per acceptance, no acceptance during a response, and pulses confined to response cycles. They also check that errored responses never carry side effects, that pending-set identities are always nonzero and in range, and that `set_valid` is always paired with a matching `eval_valid`. Only the bench's scenarios can show that a given address and data produce the right decision. That covers dropping identity 0 and identities past the limit, ignoring the big-endian word, the exact boundary where the map ends, and the page drawn from the address. Those cases need the bench's reference model, because the assertions cannot see the expected identity.

// File: rtl/msi_write_decoder.sv
module msi_write_decoder #(
  parameter int NUM_PAGES  = 4,
  parameter int NUM_IDS    = 64,
  parameter int ADDR_W     = 16,
  parameter int PAGE_SHIFT = 12,
  localparam int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int ID_W      = $clog2(NUM_IDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              set_valid,
  output logic [PAGE_W-1:0] set_page,
  output logic [ID_W-1:0]   set_id,
  output logic              eval_valid,
  output logic [PAGE_W-1:0] eval_page
);

  localparam logic [ADDR_W:0] MAP_LIMIT = (ADDR_W+1)'(NUM_PAGES) << PAGE_SHIFT;
  localparam logic [31:0]     ID_LIMIT  = 32'(NUM_IDS);

  logic accept, misaligned, out_of_range, bad, at_set_word, id_ok;
  logic [PAGE_W-1:0] page_idx;

  assign req_ready    = ~rsp_valid;
  assign accept       = req_valid & req_ready;
  assign misaligned   = (|req_addr[1:0]) | ~(&req_be);
  assign out_of_range = {1'b0, req_addr} >= MAP_LIMIT;
  assign bad          = misaligned | out_of_range;
  assign at_set_word  = req_addr[PAGE_SHIFT-1:0] == '0;
  assign id_ok        = (req_wdata != 32'd0) && (req_wdata < ID_LIMIT);
  assign page_idx     = req_addr[PAGE_SHIFT +: PAGE_W];
  assign rsp_rdata    = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      set_valid  <= 1'b0;
      eval_valid <= 1'b0;
      set_page   <= '0;
      set_id     <= '0;
      eval_page  <= '0;
    end else begin
      rsp_valid  <= accept;
      rsp_err    <= accept & bad;
      eval_valid <= accept & req_write & ~bad;
      set_valid  <= accept & req_write & ~bad & at_set_word & id_ok;
      if (accept & req_write & ~bad) begin
        eval_page <= page_idx;
        set_page  <= page_idx;
        set_id    <= req_wdata[ID_W-1:0];
      end
    end
  end

endmodule

// File: rtl/msi_write_decoder_chk.sv
module msi_write_decoder_chk #(
  parameter int NUM_PAGES  = 4,
  parameter int NUM_IDS    = 64,
  parameter int ADDR_W     = 16,
  parameter int PAGE_SHIFT = 12,
  localparam int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int ID_W      = $clog2(NUM_IDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_be,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic              set_valid,
  input logic [PAGE_W-1:0] set_page,
  input logic [ID_W-1:0]   set_id,
  input logic              eval_valid,
  input logic [PAGE_W-1:0] eval_page
);

  a_r2_resp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r2_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r2_busy_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r3_err_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (!set_valid && !eval_valid));

  a_r6_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> (set_id != '0 && 32'(set_id) < 32'(NUM_IDS)));

  a_r5_page_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    eval_valid |-> (32'(eval_page) < 32'(NUM_PAGES)));

  a_r10_pulse_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid || eval_valid) |-> rsp_valid);

  a_r10_set_pairs_eval: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> (eval_valid && eval_page == set_page));

endmodule

bind msi_write_decoder msi_write_decoder_chk #(
  .NUM_PAGES(NUM_PAGES), .NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (.*);

// File: tb/tb_msi_write_decoder.sv
`timescale 1ns/1ps
module tb_msi_write_decoder;
  localparam int NUM_PAGES = 4;
  localparam int NUM_IDS   = 64;
  localparam int ADDR_W    = 16;
  localparam int PAGE_W    = 2;
  localparam int ID_W      = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0] req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, set_valid, eval_valid;
  logic [31:0] rsp_rdata;
  logic [PAGE_W-1:0] set_page, eval_page;
  logic [ID_W-1:0] set_id;

  always #2 clk = ~clk;

  msi_write_decoder #(.NUM_PAGES(NUM_PAGES), .NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .set_valid(set_valid), .set_page(set_page), .set_id(set_id),
    .eval_valid(eval_valid), .eval_page(eval_page));

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  bit m_rsp, m_err, m_set, m_eval;
  int m_page, m_id;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rsp <= 0; m_err <= 0; m_set <= 0; m_eval <= 0;
    end else if (!m_rsp && req_valid) begin
      longint a, d;
      bit bad;
      a = longint'(req_addr);
      d = longint'(req_wdata);
      bad = (a % 4 != 0) || (req_be != 4'hF) || (a >= NUM_PAGES * 4096);
      m_rsp  <= 1;
      m_err  <= bad;
      m_eval <= req_write && !bad;
      m_set  <= req_write && !bad && (a % 4096 == 0) && d > 0 && d < NUM_IDS;
      m_page <= int'(a / 4096);
      m_id   <= int'(d);
    end else begin
      m_rsp <= 0; m_err <= 0; m_set <= 0; m_eval <= 0;
    end
  end

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("req_ready", req_ready, !m_rsp);
      chk("rsp_valid", rsp_valid, m_rsp);
      chk("rsp_err", rsp_err, m_err);
      chk("rsp_rdata", rsp_rdata, 0);
      chk("set_valid", set_valid, m_set);
      chk("eval_valid", eval_valid, m_eval);
      if (m_set) begin
        chk("set_id", set_id, m_id);
        chk("set_page", set_page, m_page);
      end
      if (m_eval) chk("eval_page", eval_page, m_page);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic xfer(string t, bit wr, int addr, logic [3:0] be, logic [31:0] data);
    @(negedge clk);
    tag = t;
    req_valid = 1; req_write = wr; req_addr = ADDR_W'(addr); req_be = be; req_wdata = data;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("rst rsp_valid", rsp_valid, 0);
    chk("rst set_valid", set_valid, 0);
    chk("rst eval_valid", eval_valid, 0);
    chk("rst req_ready", req_ready, 1);
    rst_n = 1;
    idle(2);
    xfer("R6", 1, 16'h0000, 4'hF, 5);          idle(1);
    xfer("R6", 1, 16'h1000, 4'hF, 63);         idle(1);
    xfer("R5", 1, 16'h3000, 4'hF, 1);          idle(1);
    xfer("R5", 1, 16'h2000, 4'hF, 42);         idle(1);
    xfer("R7", 1, 16'h0000, 4'hF, 0);          idle(1);
    xfer("R7", 1, 16'h1000, 4'hF, 64);         idle(1);
    xfer("R7", 1, 16'h2000, 4'hF, 32'hFFFFFFFF); idle(1);
    xfer("R8", 1, 16'h0004, 4'hF, 7);          idle(1);
    xfer("R8", 1, 16'h3100, 4'hF, 9);          idle(1);
    xfer("R3", 1, 16'h1002, 4'hF, 3);          idle(1);
    xfer("R3", 1, 16'h1000, 4'b0011, 3);       idle(1);
    xfer("R4", 1, 16'h4000, 4'hF, 3);          idle(1);
    xfer("R4", 1, 16'hFFFC, 4'hF, 3);          idle(1);
    xfer("R4", 1, 16'h3FFC, 4'hF, 3);          idle(1);
    xfer("R9", 0, 16'h0000, 4'hF, 5);          idle(1);
    xfer("R9", 0, 16'h4000, 4'hF, 5);          idle(1);
    xfer("R9", 0, 16'h1001, 4'hF, 5);          idle(1);
    xfer("R2", 1, 16'h0000, 4'hF, 10);
    xfer("R2", 1, 16'h1000, 4'hF, 11);
    xfer("R10", 1, 16'h2000, 4'hF, 12);
    xfer("R10", 1, 16'h3004, 4'hF, 13);
    xfer("R10", 0, 16'h3000, 4'hF, 14);
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule